// File: doc/BRIEF.md
# Staggered-Output Latched Serial LED Driver Core

This block is the digital control core of a multi-channel LED sink driver fed over a serial link. Bits arrive on a serial data pin and enter a shift register on each rising edge of a serial clock. A latch-enable input copies the shift register into a bank of output latches. An active-low output-enable input gates the channel outputs. The last shift register stage is presented on a serial data output, so several devices can be chained.

Channel outputs never switch together. When a refresh is triggered, channel 0 takes its latched bit first. Each higher channel follows one stagger interval later, so channel k changes k intervals after channel 0. This spreads the inrush current over time. The stagger interval is a parameter counted in system clock cycles. A refresh is triggered by four events: output-enable falling, latch-enable rising while outputs are enabled, a serial clock edge while the latch is transparent and outputs are enabled, and recovery from overtemperature.

Two fault flags come in as digital inputs. Undervoltage blanks the outputs and clears all stored state. Overtemperature blanks the outputs. In normal mode the stored data is kept. In open-LED-detect mode the overtemperature event also wipes the shift register.

Top module: `stagger_led_ctrl`

## Requirements
- R1: After reset, every channel output is 0, the serial data output is 0 and the operating mode is normal.
- R2: On every rising edge of `sclk_i`, the shift register moves one place toward bit N_CH-1 and takes `sdata_i` into bit 0. `sdata_o` shows bit N_CH-1 from the clock cycle after that edge.
- R3: While `latch_i` is 1, the output latches are loaded with the shift register contents. While `latch_i` is 0, the latches keep their value, even while new bits are shifted in.
- R4: In a refresh whose trigger is seen at clock edge T, channel k takes its latch bit at edge T+1+k*STEP_CYC. Channels not yet reached keep their previous value. While `oe_n_i` is 1, every output is 0 from the next clock edge on.
- R5: A falling edge of `oe_n_i`, with no fault flag set, triggers a refresh.
- R6: A rising edge of `latch_i` while `oe_n_i` is 0 triggers a refresh that uses the newly latched data.
- R7: While `latch_i` is held 1 and `oe_n_i` is 0, each rising edge of `sclk_i` triggers a refresh with the newly shifted data.
- R8: A trigger that arrives during a refresh restarts the sequence from channel 0 with the current latch data. Channels already updated keep their new values until they are reached again.
- R9: While `uvlo_i` is 1, all outputs are 0 and the shift register, latches and mode are held cleared (mode normal). Releasing `uvlo_i` triggers no refresh.
- R10: While `otemp_i` is 1, all outputs are 0. In normal mode the shift register and latches keep their contents. When `otemp_i` falls with `oe_n_i` at 0, a refresh restores the latched data.
- R11: In open-LED-detect mode, while `otemp_i` is 1 the shift register is also held at 0. The latches are kept.
- R12: The mode is taken from `detect_mode_i` (0 normal, 1 open-LED-detect) on each rising edge of `latch_i`. Between those edges it is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock, sampled on clk |
| sdata_i | input | 1 | Serial data in |
| latch_i | input | 1 | Latch enable, transparent while 1 |
| oe_n_i | input | 1 | Output enable, active low |
| uvlo_i | input | 1 | Undervoltage lockout flag |
| otemp_i | input | 1 | Overtemperature flag |
| detect_mode_i | input | 1 | Mode request: 0 normal, 1 open-LED-detect |
| sdata_o | output | 1 | Serial data out (last shift stage) |
| drive_o | output | N_CH | Channel on/off outputs |

## Verification
The assertions assume that every control input is already synchronous to `clk` and changes only between clock edges. They also assume that the serial clock is low for at least one system cycle between rising edges, so each edge is seen exactly once. The bench drives all inputs on the falling edge of `clk`. Its serial clock stays high for one cycle and low for one cycle. It samples outputs on the falling edge as well, which keeps its stimulus inside those assumptions. The stability property treats the blanking inputs and the per-channel update strobes as the only causes of an output change. The bench therefore raises no input that moves the outputs through any other path.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_DETECT = 1'b1
  } drv_mode_e;

  typedef struct packed {
    logic sclk_rise;
    logic latch_rise;
    logic oe_fall;
    logic otemp_fall;
  } edge_evt_t;

endpackage

// File: rtl/in_edges.sv
module in_edges
  import led_drv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_i,
  input  logic      latch_i,
  input  logic      oe_n_i,
  input  logic      otemp_i,
  output edge_evt_t evt_o
);

  logic sclk_q, latch_q, oe_n_q, otemp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      latch_q <= 1'b0;
      oe_n_q  <= 1'b1;
      otemp_q <= 1'b0;
    end else begin
      sclk_q  <= sclk_i;
      latch_q <= latch_i;
      oe_n_q  <= oe_n_i;
      otemp_q <= otemp_i;
    end
  end

  always_comb begin
    evt_o.sclk_rise  = sclk_i & ~sclk_q;
    evt_o.latch_rise = latch_i & ~latch_q;
    evt_o.oe_fall    = ~oe_n_i & oe_n_q;
    evt_o.otemp_fall = ~otemp_i & otemp_q;
  end

endmodule

// File: rtl/shift_latch.sv
module shift_latch
  import led_drv_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk_rise,
  input  logic            sdata_i,
  input  logic            latch_i,
  input  logic            latch_rise,
  input  logic            detect_mode_i,
  input  logic            uvlo_i,
  input  logic            otemp_i,
  output logic [N_CH-1:0] lat_o,
  output logic            sdata_o
);

  logic [N_CH-1:0] sr_q, sr_d;
  logic [N_CH-1:0] lat_q, lat_d;
  drv_mode_e       mode_q, mode_d;

  // next state
  always_comb begin
    sr_d = sr_q;
    if (sclk_rise) sr_d = {sr_q[N_CH-2:0], sdata_i};
    if (uvlo_i) sr_d = '0;
    else if (otemp_i && (mode_q == MODE_DETECT)) sr_d = '0;

    lat_d = lat_q;
    if (latch_i) lat_d = sr_d;
    if (uvlo_i) lat_d = '0;

    mode_d = mode_q;
    if (uvlo_i) mode_d = MODE_NORMAL;
    else if (latch_rise) mode_d = drv_mode_e'(detect_mode_i);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      lat_q  <= '0;
      mode_q <= MODE_NORMAL;
    end else begin
      sr_q   <= sr_d;
      lat_q  <= lat_d;
      mode_q <= mode_d;
    end
  end

  assign lat_o   = lat_q;
  assign sdata_o = sr_q[N_CH-1];

endmodule

// File: rtl/stagger_seq.sv
module stagger_seq #(
  parameter int N_CH     = 8,
  parameter int STEP_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            abort_i,
  output logic [N_CH-1:0] upd_o
);

  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int CNT_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_CH - 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STEP_CYC - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fire;

  assign fire = busy_q && (cnt_q == '0) && !start_i && !abort_i;

  for (genvar g = 0; g < N_CH; g++) begin : g_dec
    assign upd_o[g] = fire && (idx_q == IDX_W'(g));
  end

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    if (abort_i) begin
      busy_d = 1'b0;
    end else if (start_i) begin
      busy_d = 1'b1;
      idx_d  = '0;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        if (idx_q == IDX_LAST) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          cnt_d = CNT_LOAD;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/chan_drive.sv
module chan_drive #(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            blank_i,
  input  logic [N_CH-1:0] upd_i,
  input  logic [N_CH-1:0] lat_i,
  output logic [N_CH-1:0] drive_o
);

  logic [N_CH-1:0] drv_q, drv_d;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    always_comb begin
      drv_d[g] = drv_q[g];
      if (blank_i) drv_d[g] = 1'b0;
      else if (upd_i[g]) drv_d[g] = lat_i[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= '0;
    else        drv_q <= drv_d;
  end

  assign drive_o = drv_q;

endmodule

// File: rtl/stagger_led_ctrl.sv
module stagger_led_ctrl
  import led_drv_pkg::*;
#(
  parameter int N_CH     = 8,
  parameter int STEP_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk_i,
  input  logic            sdata_i,
  input  logic            latch_i,
  input  logic            oe_n_i,
  input  logic            uvlo_i,
  input  logic            otemp_i,
  input  logic            detect_mode_i,
  output logic            sdata_o,
  output logic [N_CH-1:0] drive_o
);

  edge_evt_t       evt;
  logic [N_CH-1:0] lat_q;
  logic [N_CH-1:0] upd_vec;
  logic            blank;
  logic            trig;

  in_edges u_edges (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_i  (sclk_i),
    .latch_i (latch_i),
    .oe_n_i  (oe_n_i),
    .otemp_i (otemp_i),
    .evt_o   (evt)
  );

  shift_latch #(.N_CH(N_CH)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .sclk_rise     (evt.sclk_rise),
    .sdata_i       (sdata_i),
    .latch_i       (latch_i),
    .latch_rise    (evt.latch_rise),
    .detect_mode_i (detect_mode_i),
    .uvlo_i        (uvlo_i),
    .otemp_i       (otemp_i),
    .lat_o         (lat_q),
    .sdata_o       (sdata_o)
  );

  // blanking sources and refresh triggers
  assign blank = oe_n_i | uvlo_i | otemp_i;
  assign trig  = !blank && (evt.oe_fall || evt.latch_rise || evt.otemp_fall ||
                            (latch_i && evt.sclk_rise));

  stagger_seq #(.N_CH(N_CH), .STEP_CYC(STEP_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (trig),
    .abort_i (blank),
    .upd_o   (upd_vec)
  );

  chan_drive #(.N_CH(N_CH)) u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .blank_i (blank),
    .upd_i   (upd_vec),
    .lat_i   (lat_q),
    .drive_o (drive_o)
  );

endmodule

// File: rtl/stagger_led_ctrl_chk.sv
module stagger_led_ctrl_chk #(
  parameter int N_CH = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            oe_n_i,
  input logic            uvlo_i,
  input logic            otemp_i,
  input logic            sdata_o,
  input logic [N_CH-1:0] drive_o,
  input logic [N_CH-1:0] upd_vec
);

  // R4: output enable high blanks all channels at the next edge
  p_oe_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |=> (drive_o == '0));

  // R9: undervoltage blanks the outputs
  p_uvlo_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |=> (drive_o == '0));

  // R9: undervoltage clears the shift register, visible on the serial output
  p_uvlo_sdo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |=> (sdata_o == 1'b0));

  // R10: overtemperature blanks the outputs
  p_otemp_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    otemp_i |=> (drive_o == '0));

  // R4: the sequencer updates at most one channel per cycle
  p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_vec));

  // R4: without blanking or an update strobe, outputs hold
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n_i && !uvlo_i && !otemp_i && (upd_vec == '0)) |=> $stable(drive_o));

endmodule

bind stagger_led_ctrl stagger_led_ctrl_chk #(.N_CH(N_CH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .oe_n_i  (oe_n_i),
  .uvlo_i  (uvlo_i),
  .otemp_i (otemp_i),
  .sdata_o (sdata_o),
  .drive_o (drive_o),
  .upd_vec (upd_vec)
);

// File: tb/stagger_led_ctrl_tb_top.sv
module stagger_led_ctrl_tb_top;

  localparam int N = 8;
  localparam int S = 3;
  localparam int LAST = 2 + (N - 1) * S + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic sclk_i, sdata_i, latch_i, oe_n_i, uvlo_i, otemp_i, detect_mode_i;
  logic sdata_o;
  logic [N-1:0] drive_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stagger_led_ctrl #(.N_CH(N), .STEP_CYC(S)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sclk_i        (sclk_i),
    .sdata_i       (sdata_i),
    .latch_i       (latch_i),
    .oe_n_i        (oe_n_i),
    .uvlo_i        (uvlo_i),
    .otemp_i       (otemp_i),
    .detect_mode_i (detect_mode_i),
    .sdata_o       (sdata_o),
    .drive_o       (drive_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic shift_byte(input logic [N-1:0] b);
    for (int i = N - 1; i >= 0; i--) begin
      @(negedge clk); sdata_i = b[i]; sclk_i = 1'b1;
      @(negedge clk); sclk_i = 1'b0;
    end
  endtask

  function automatic logic [N-1:0] stag_exp(input logic [N-1:0] o, input logic [N-1:0] n, input int j);
    logic [N-1:0] e;
    for (int k = 0; k < N; k++) e[k] = (j >= 2 + k * S) ? n[k] : o[k];
    return e;
  endfunction

  // trigger already driven before the next edge; checks every cycle of the ripple
  task automatic stagger_check(input logic [N-1:0] o, input logic [N-1:0] n, input bit drop_latch, input string tag);
    for (int j = 1; j <= LAST; j++) begin
      @(negedge clk);
      chk(drive_o == stag_exp(o, n, j), tag, drive_o, stag_exp(o, n, j));
      if (j == 1) begin
        sclk_i = 1'b0;
        if (drop_latch) latch_i = 1'b0;
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; sclk_i = 0; sdata_i = 0; latch_i = 0; oe_n_i = 1;
    uvlo_i = 0; otemp_i = 0; detect_mode_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(drive_o == '0, "R1 outputs", drive_o, 0);
    chk(sdata_o == 1'b0, "R1 serial out", sdata_o, 0);
  endtask

  task automatic t_oe_fall;
    shift_byte(8'hA5);
    chk(sdata_o == 1'b1, "R2 serial out", sdata_o, 1);
    @(negedge clk); latch_i = 1'b1;
    @(negedge clk); latch_i = 1'b0;
    @(negedge clk);
    chk(drive_o == '0, "R4 oe high blanks", drive_o, 0);
    oe_n_i = 1'b0;
    stagger_check('0, 8'hA5, 0, "R5 oe fall ripple");
  endtask

  task automatic t_latch_rise;
    shift_byte(8'h3C);
    chk(sdata_o == 1'b0, "R2 serial out", sdata_o, 0);
    chk(drive_o == 8'hA5, "R3 latch holds", drive_o, 8'hA5);
    @(negedge clk); latch_i = 1'b1;
    stagger_check(8'hA5, 8'h3C, 1, "R6 latch rise ripple");
  endtask

  task automatic t_transparent;
    logic [N-1:0] x0, s1, s2, o2;
    @(negedge clk); latch_i = 1'b1;
    stagger_check(8'h3C, 8'h3C, 0, "R6 latch rise same data");
    sdata_i = 1'b1; sclk_i = 1'b1;
    stagger_check(8'h3C, 8'h79, 0, "R7 clock edge ripple");
    x0 = 8'h79; s1 = {x0[N-2:0], 1'b1}; s2 = {s1[N-2:0], 1'b0};
    sdata_i = 1'b1; sclk_i = 1'b1;
    for (int j = 1; j < 6; j++) begin
      @(negedge clk);
      chk(drive_o == stag_exp(x0, s1, j), "R8 first ripple", drive_o, stag_exp(x0, s1, j));
      if (j == 1) sclk_i = 1'b0;
    end
    @(negedge clk);
    for (int k = 0; k < N; k++) o2[k] = (2 + k * S <= 6) ? s1[k] : x0[k];
    chk(drive_o == o2, "R8 before restart", drive_o, o2);
    sdata_i = 1'b0; sclk_i = 1'b1;
    stagger_check(o2, s2, 0, "R8 restart ripple");
    @(negedge clk); latch_i = 1'b0;
  endtask

  task automatic t_oe_high;
    @(negedge clk); oe_n_i = 1'b1;
    @(negedge clk);
    chk(drive_o == '0, "R4 oe high blanks", drive_o, 0);
    oe_n_i = 1'b0;
    stagger_check('0, 8'hE6, 0, "R5 oe fall again");
  endtask

  task automatic t_otemp_normal;
    @(negedge clk); otemp_i = 1'b1;
    @(negedge clk);
    chk(drive_o == '0, "R10 otemp blanks", drive_o, 0);
    repeat (3) @(negedge clk);
    chk(sdata_o == 1'b1, "R10 register kept", sdata_o, 1);
    otemp_i = 1'b0;
    stagger_check('0, 8'hE6, 0, "R10 resume ripple");
  endtask

  task automatic t_otemp_detect;
    @(negedge clk); detect_mode_i = 1'b1; latch_i = 1'b1;
    stagger_check(8'hE6, 8'hE6, 1, "R12 mode load");
    otemp_i = 1'b1;
    @(negedge clk);
    chk(drive_o == '0, "R11 otemp blanks", drive_o, 0);
    chk(sdata_o == 1'b0, "R11 register wiped", sdata_o, 0);
    @(negedge clk); otemp_i = 1'b0;
    stagger_check('0, 8'hE6, 0, "R11 latch kept");
    latch_i = 1'b1;
    stagger_check(8'hE6, '0, 1, "R11 shift register zero");
  endtask

  task automatic t_uvlo;
    shift_byte(8'hFF);
    @(negedge clk); latch_i = 1'b1;
    stagger_check('0, 8'hFF, 1, "R3 load before uvlo");
    uvlo_i = 1'b1;
    @(negedge clk);
    chk(drive_o == '0, "R9 uvlo blanks", drive_o, 0);
    chk(sdata_o == 1'b0, "R9 serial cleared", sdata_o, 0);
    repeat (3) @(negedge clk);
    uvlo_i = 1'b0;
    repeat (LAST) @(negedge clk);
    chk(drive_o == '0, "R9 no refresh on release", drive_o, 0);
    oe_n_i = 1'b1;
    @(negedge clk); oe_n_i = 1'b0;
    stagger_check('0, '0, 0, "R9 latch cleared");
    for (int i = 0; i < N - 1; i++) begin
      @(negedge clk); sdata_i = 1'b1; sclk_i = 1'b1;
      @(negedge clk); sclk_i = 1'b0;
      chk(sdata_o == 1'b0, "R9 shift register cleared", sdata_o, 0);
    end
    @(negedge clk); otemp_i = 1'b1;
    repeat (2) @(negedge clk);
    otemp_i = 1'b0;
    @(negedge clk); sdata_i = 1'b1; sclk_i = 1'b1;
    @(negedge clk); sclk_i = 1'b0;
    chk(sdata_o == 1'b1, "R9 mode back to normal", sdata_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_oe_fall();
    t_latch_rise();
    t_transparent();
    t_oe_high();
    t_otemp_normal();
    t_otemp_detect();
    t_uvlo();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule